// File: doc/BRIEF.md
# T1 Transmit Error Injector

This block sits in the transmit bit path of a T1 framer, just ahead of the line encoder. Each transmit bit arrives with a tag that says where it lies in the frame: payload (with a first-bit-of-timeslot flag), terminal framing bit, signalling framing bit, CRC-6 bit (with its index within the extended superframe), or data link bit. The block forwards the bit and corrupts it when a control register asks for it. It also raises a violation request flag that tells the line encoder to send the current mark with the wrong polarity.

Five error classes are one-shot. Software writes a 1 to arm a class. The error is applied to the next bit that qualifies, and the arming bit then clears itself. The loss-of-signal control is a level. While it is set the line carries no pulses at all: the bit that zero code suppression substituted is ignored, and no other error is applied.

The bit stream uses a valid/ready handshake with no storage. `in_ready` follows `out_ready` and `out_valid` follows `in_valid` in the same cycle. A bit counts as transferred only in a cycle where `in_valid` and `out_ready` are both high. Back-pressure therefore holds the upstream bit in place, and no one-shot is consumed while the bit is stalled.

Top module: `t1_err_inject`

## Requirements
- R1: After reset, `ctl_rdata` reads 0: nothing is armed and loss of signal is off.
- R2: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, both combinationally. A one-shot is consumed only in a cycle where `in_valid` and `out_ready` are both high.
- R3: The control bits are: bit 0 violation, bit 1 CRC-6, bit 2 terminal framing, bit 3 signalling framing, bit 4 payload, bit 5 loss of signal. A write sets each one-shot whose data bit is 1 and leaves a one-shot unchanged when its data bit is 0. Bit 5 takes the written value. `ctl_rdata` shows the register one cycle after the write.
- R4: When nothing fires, `out_bit` equals `in_zcs_bit` if `zcs_on` is 1 and `in_bit` otherwise. A bit is never inverted more than once.
- R5: An armed terminal framing error inverts the next transferred bit with `in_kind`=1, then clears.
- R6: An armed signalling framing error inverts the next transferred bit with `in_kind`=2, then clears.
- R7: An armed CRC-6 error inverts the next transferred bit with `in_kind`=3 whose `in_crc_idx` equals parameter `CRC_BIT` (default 0), then clears. CRC bits with other indices pass unchanged.
- R8: An armed payload error inverts the next transferred bit with `in_kind`=0 and `in_slot_first`=1, then clears. Payload bits with `in_slot_first`=0 and data link bits (`in_kind`=4) are never targeted.
- R9: An armed violation error raises `out_bpv` on the next transferred bit whose `out_bit` is 1, then clears. `out_bpv` is never high on a 0.
- R10: While loss of signal is set, `out_bit` and `out_bpv` are 0 whatever `in_bit`, `in_zcs_bit` and `zcs_on` are. Armed one-shots stay armed, and they fire normally once loss of signal is cleared.
- R11: If a write arms a class in the same cycle that the class fires, the class stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data |
| ctl_rdata | output | 6 | Control register contents |
| zcs_on | input | 1 | Selects the zero-suppression-substituted bit as the data source |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Block can take the input bit |
| in_bit | input | 1 | Raw transmit bit |
| in_zcs_bit | input | 1 | Transmit bit after zero code substitution |
| in_kind | input | 3 | Position tag: 0 payload, 1 terminal framing, 2 signalling framing, 3 CRC-6, 4 data link |
| in_crc_idx | input | 3 | CRC-6 bit index within the superframe |
| in_slot_first | input | 1 | First bit of a payload timeslot |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Line encoder takes the output bit |
| out_bit | output | 1 | Possibly corrupted line bit |
| out_bpv | output | 1 | Request to send this mark as a bipolar violation |

## Verification
With nothing armed, the bench sweeps every combination of position tag, CRC index, slot flag, both data bits, `zcs_on` and the handshake. This separates source selection from stalls. Each one-shot class is then armed in turn and driven by a pseudo-random stream of tagged bits. The stream shows whether the error lands on the first qualifying position only, skips positions that look similar (other CRC indices, non-first payload bits, data link bits, spaces for the violation), and clears afterwards. Loss of signal is tested with every class armed and with `in_zcs_bit` high. Separate cases cover a write that coincides with a firing, a zero write, and a stalled transfer.

// File: rtl/t1ei_pkg.sv
`timescale 1ns/1ps
package t1ei_pkg;
  localparam int NSHOT  = 5;
  localparam int CTL_W  = NSHOT + 1;
  localparam int I_BPV  = 0;
  localparam int I_CRC  = 1;
  localparam int I_FT   = 2;
  localparam int I_FS   = 3;
  localparam int I_PAY  = 4;
  localparam int I_LOS  = NSHOT;
  localparam int KIND_W = 3;
  localparam int IDX_W  = 3;

  typedef enum logic [KIND_W-1:0] {
    K_PAY = 3'd0,
    K_FT  = 3'd1,
    K_FS  = 3'd2,
    K_CRC = 3'd3,
    K_DL  = 3'd4
  } kind_e;
endpackage

// File: rtl/t1ei_ctl.sv
`timescale 1ns/1ps
module t1ei_ctl
  import t1ei_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic [NSHOT-1:0] fire,
  output logic [NSHOT-1:0] armed,
  output logic             los
);
  // One-shot arm flags: a write that sets the flag wins over its consumption.
  for (genvar g = 0; g < NSHOT; g++) begin : g_shot
    always_ff @(posedge clk) begin
      if (!rst_n)                armed[g] <= 1'b0;
      else if (wr && wdata[g])   armed[g] <= 1'b1;
      else if (fire[g])          armed[g] <= 1'b0;
    end

    // R5 R6 R7 R8 R9: a fired class clears unless rearmed
    a_r9_oneshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] && !(wr && wdata[g]) |=> !armed[g]);
    // R11: arming write wins over a simultaneous firing
    a_r11_rearm_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr && wdata[g] |=> armed[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  los <= 1'b0;
    else if (wr) los <= wdata[I_LOS];
  end

  // R10: nothing is consumed while loss of signal holds
  a_r10_los_keeps_armed: assert property (@(posedge clk) disable iff (!rst_n)
    los && !wr |=> $stable(armed));
  // R3: a zero write never clears an armed class
  a_r3_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wdata[NSHOT-1:0] == '0 && fire == '0 |=> $stable(armed));
endmodule

// File: rtl/t1ei_elig.sv
`timescale 1ns/1ps
module t1ei_elig
  import t1ei_pkg::*;
#(
  parameter logic [IDX_W-1:0] CRC_BIT = '0
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [IDX_W-1:0]  crc_idx,
  input  logic              slot_first,
  output logic [NSHOT-1:0]  pos_ok
);
  kind_e k;
  always_comb begin
    k             = kind_e'(kind);
    pos_ok        = '0;
    pos_ok[I_BPV] = 1'b1;  // any position; gated by mark in the path
    pos_ok[I_CRC] = (k == K_CRC) && (crc_idx == CRC_BIT);
    pos_ok[I_FT]  = (k == K_FT);
    pos_ok[I_FS]  = (k == K_FS);
    pos_ok[I_PAY] = (k == K_PAY) && slot_first;
  end
endmodule

// File: rtl/t1ei_path.sv
`timescale 1ns/1ps
module t1ei_path
  import t1ei_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             los,
  input  logic [NSHOT-1:0] armed,
  input  logic [NSHOT-1:0] pos_ok,
  input  logic             src_bit,
  output logic             line_bit,
  output logic             bpv,
  output logic [NSHOT-1:0] fire
);
  logic [NSHOT-1:0] hit;
  logic             flip;

  always_comb begin
    hit             = armed & pos_ok & {NSHOT{beat && !los}};
    fire            = hit;
    fire[I_BPV]     = 1'b0;
    flip            = |hit[NSHOT-1:1];
    line_bit        = los ? 1'b0 : (src_bit ^ flip);
    fire[I_BPV]     = hit[I_BPV] && line_bit;
    bpv             = fire[I_BPV];
  end

  // R4: at most one inversion per bit
  a_r4_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire[NSHOT-1:1]));
  // R10: silent line while loss of signal holds
  a_r10_silent: assert property (@(posedge clk) disable iff (!rst_n)
    los |-> !line_bit && !bpv && fire == '0);
endmodule

// File: rtl/t1_err_inject.sv
`timescale 1ns/1ps
module t1_err_inject
  import t1ei_pkg::*;
#(
  parameter logic [IDX_W-1:0] CRC_BIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             zcs_on,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             in_zcs_bit,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [IDX_W-1:0] in_crc_idx,
  input  logic             in_slot_first,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             out_bpv
);
  logic [NSHOT-1:0] armed, pos_ok, fire;
  logic             los, beat, src_bit;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign beat      = in_valid && out_ready;
  assign src_bit   = zcs_on ? in_zcs_bit : in_bit;
  assign ctl_rdata = {los, armed};

  t1ei_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .fire(fire), .armed(armed), .los(los)
  );

  t1ei_elig #(.CRC_BIT(CRC_BIT)) u_elig (
    .kind(in_kind), .crc_idx(in_crc_idx), .slot_first(in_slot_first),
    .pos_ok(pos_ok)
  );

  t1ei_path u_path (
    .clk(clk), .rst_n(rst_n), .beat(beat), .los(los), .armed(armed),
    .pos_ok(pos_ok), .src_bit(src_bit), .line_bit(out_bit),
    .bpv(out_bpv), .fire(fire)
  );

  // R9: violation only on a transferred mark
  a_r9_bpv_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
    out_bpv |-> out_bit && in_valid && out_ready);
  // R2: a stalled bit consumes nothing
  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && out_ready) && !ctl_wr |=> $stable(ctl_rdata));
  // R10: the line stays silent even when the substituted bit is a one
  a_r10_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[I_LOS] && in_zcs_bit |-> !out_bit);
endmodule

// File: tb/t1_err_inject_test.sv
`timescale 1ns/1ps
module t1_err_inject_test;
  localparam logic [2:0] CRC_BIT = 3'd0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [5:0] ctl_rdata;
  logic       zcs_on = 1'b0, in_valid = 1'b0, in_ready, in_bit = 1'b0, in_zcs_bit = 1'b0;
  logic [2:0] in_kind = '0, in_crc_idx = '0;
  logic       in_slot_first = 1'b0, out_valid, out_ready = 1'b0, out_bit, out_bpv;

  int checks = 0, errors = 0;
  logic [4:0] m_armed = '0;
  logic       m_los = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  t1_err_inject #(.CRC_BIT(CRC_BIT)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .zcs_on(zcs_on), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .in_zcs_bit(in_zcs_bit),
    .in_kind(in_kind), .in_crc_idx(in_crc_idx), .in_slot_first(in_slot_first),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_bpv(out_bpv)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag);
    @(negedge clk); ctl_wr = 1'b0; in_valid = 1'b0; #1;
    chk(tag, {2'b0, ctl_rdata}, {2'b0, m_los, m_armed});
  endtask

  // One cycle: drive at negedge, check 1 ns later, model update at posedge.
  task automatic cyc(input logic [2:0] k, input logic [2:0] ci, input logic sf,
                     input logic b, input logic z, input logic zon,
                     input logic v, input logic r, input logic wr, input logic [5:0] wd);
    logic base, acc, inv, eb, ebpv;
    logic [4:0] fired;
    string tag;
    @(negedge clk);
    in_kind = k; in_crc_idx = ci; in_slot_first = sf; in_bit = b; in_zcs_bit = z;
    zcs_on = zon; in_valid = v; out_ready = r; ctl_wr = wr; ctl_wdata = wd;
    #1;
    base = zon ? z : b;
    acc = v && r && !m_los;
    fired = '0;
    fired[1] = acc && m_armed[1] && k == 3'd3 && ci == CRC_BIT;
    fired[2] = acc && m_armed[2] && k == 3'd1;
    fired[3] = acc && m_armed[3] && k == 3'd2;
    fired[4] = acc && m_armed[4] && k == 3'd0 && sf;
    inv  = |fired[4:1];
    eb   = m_los ? 1'b0 : base ^ inv;
    ebpv = acc && m_armed[0] && eb;
    fired[0] = ebpv;
    if (m_los) tag = "R10";
    else if (fired[2]) tag = "R5";
    else if (fired[3]) tag = "R6";
    else if (fired[1]) tag = "R7";
    else if (fired[4]) tag = "R8";
    else if (m_armed[0]) tag = "R9";
    else tag = "R4";
    chk("R2 valid/ready", {6'b0, out_valid, in_ready}, {6'b0, v, r});
    chk(tag, {6'b0, out_bit, out_bpv}, {6'b0, eb, ebpv});
    @(posedge clk);
    m_armed = (m_armed & ~fired) | (wr ? wd[4:0] : 5'b0);
    if (wr) m_los = wd[5];
  endtask

  task automatic wr_ctl(input logic [5:0] wd);
    cyc(3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, wd);
  endtask

  task automatic rnd_beats(input int n, input logic zon);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(3'(lfsr[2:0] % 5), 3'(lfsr[5:3] % 6), lfsr[6], lfsr[7], lfsr[8], zon,
          1'b1, lfsr[9] | lfsr[11], 1'b0, 6'b0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk_rd("R1 reset");
    // R4 / R2: exhaustive pass-through sweep, nothing armed
    for (int k = 0; k < 5; k++)
      for (int ci = 0; ci < 6; ci++)
        for (int m = 0; m < 64; m++)
          cyc(3'(k), 3'(ci), m[0], m[1], m[2], m[3], m[4], m[5], 1'b0, 6'b0);
    chk_rd("R4 nothing armed");
    // R5..R9: each class alone, then check self-clear
    for (int c = 0; c < 5; c++) begin
      wr_ctl(6'(1 << c));
      chk_rd("R3 arm readback");
      rnd_beats(60, c[0]);
      chk_rd(c == 0 ? "R9 cleared" : c == 1 ? "R7 cleared" : c == 2 ? "R5 cleared" :
             c == 3 ? "R6 cleared" : "R8 cleared");
    end
    // R3: zero write keeps arms
    wr_ctl(6'b011111);
    wr_ctl(6'b000000);
    chk_rd("R3 zero write");
    // R10: LOS with everything armed, substituted ones present
    wr_ctl(6'b111111);
    chk_rd("R10 los set");
    for (int i = 0; i < 5; i++) cyc(3'(i), CRC_BIT, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6'b0);
    rnd_beats(30, 1'b1);
    chk_rd("R10 arms kept");
    wr_ctl(6'b000000);
    rnd_beats(80, 1'b0);
    chk_rd("R10 fired after release");
    // R11: arm terminal framing, fire it while rewriting it
    wr_ctl(6'b000100);
    cyc(3'd1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'b000100);
    chk_rd("R11 rearm wins");
    cyc(3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'b0);
    chk_rd("R5 second fire clears");
    // R2: stalled payload bit consumes nothing
    wr_ctl(6'b010000);
    cyc(3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b0);
    chk_rd("R2 stall keeps arm");
    cyc(3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'b0);
    chk_rd("R8 fired after stall");
    // R9: violation skips spaces
    wr_ctl(6'b000001);
    cyc(3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'b0);
    chk_rd("R9 space skipped");
    cyc(3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'b0);
    chk_rd("R9 mark consumed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule